// File: doc/BRIEF.md
# Modem Line Control and Status Registers

This block keeps the two byte-wide modem registers of a classic serial port: a control register that drives the four handshake outputs and a status register that follows the four handshake inputs. The four inputs are clear-to-send, data-set-ready, carrier-detect and ring. The four outputs are data-terminal-ready, request-to-send and two general-purpose outputs. The inputs arrive from pins that are not synchronous to the block clock. They pass through a synchroniser, and the block then compares each new line level with the level it holds. A change sets a sticky delta flag. For the ring line the flag is set only on its falling (trailing) edge.

Software reaches both registers through one select-based byte port. A read strobe on the status register clears the delta flags. A single change-indication output goes to the interrupt logic. A loopback test mode isolates the external outputs. In that mode status reads show an image of the control bits.

Top module: `mdm_regs`

## Requirements
- R1: After reset the status register reads 0xB0, the control register reads 0x08, out2_o is 1, dtr_o, rts_o and out1_o are 0, and msc_irq_o is 0.
- R2: The status register layout is bit7 carrier, bit6 ring, bit5 data-set-ready, bit4 clear-to-send, bit3 carrier delta, bit2 ring trailing edge, bit1 data-set-ready delta, bit0 clear-to-send delta. When a synchronised carrier, data-set-ready or clear-to-send level differs from the stored level, the level bit is updated and its delta bit is set. Delta bits stay set until cleared.
- R3: Bit 2 is set only when the stored ring level goes from 1 to 0. A 0-to-1 change updates bit 6 and leaves bit 2 unchanged.
- R4: A read strobe (rd_en_i=1, reg_sel_i=1, outside loopback) clears bits 3..0 at that clock edge. rdata_o shows the value before the clear during the strobe cycle. A delta produced at the same edge as the clear is kept.
- R5: A write with reg_sel_i=0 stores wdata_i[4:0] (bit0 DTR, bit1 RTS, bit2 OUT1, bit3 OUT2, bit4 LOOP). The control register reads back {3'b000, stored bits}. A write with reg_sel_i=1 changes no register.
- R6: With LOOP=0, dtr_o, rts_o, out1_o and out2_o equal control bits 0, 1, 2 and 3, active high.
- R7: With LOOP=1, all four outputs are 0. A status read returns {OUT2, OUT1, DTR, RTS, 4'b0000}. A read strobe does not clear the stored delta bits, and the stored status keeps following the inputs.
- R8: msc_irq_o is 1 exactly when any stored delta bit (bits 3..0 outside loopback) is 1.
- R9: An input change becomes visible in the status register after the third rising clock edge that follows it, and not after the first or second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_sel_i | input | 1 | 0 selects the control register, 1 the status register |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe (side effects on status) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the selected register |
| cts_i | input | 1 | Clear-to-send input, asynchronous |
| dsr_i | input | 1 | Data-set-ready input, asynchronous |
| dcd_i | input | 1 | Carrier-detect input, asynchronous |
| ri_i | input | 1 | Ring input, asynchronous |
| dtr_o | output | 1 | Data-terminal-ready output |
| rts_o | output | 1 | Request-to-send output |
| out1_o | output | 1 | General output 1 |
| out2_o | output | 1 | General output 2 |
| msc_irq_o | output | 1 | Modem status change indication |

## Verification
Directed patterns come first. A single clear-to-send drop checks the three-edge latency. A ring pulse separates the rising edge, which must set no flag, from the trailing edge, which must. A data-set-ready change landing on the same edge as a clearing read tells a lost delta from a kept one. Loopback writes with an asymmetric bit pattern expose any swapped image bit, and they show whether a loopback read wrongly clears deltas. Seeded random traffic with slowly toggling lines and mixed reads and writes then tests delta accumulation, clear timing and output gating against a bench model.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
  localparam int LINES  = 4;
  localparam int BYTE_W = 8;
  localparam int CTRL_W = 5;

  // line vector order {dcd, ri, dsr, cts}; status = {levels, deltas}
  localparam int L_CTS = 0;
  localparam int L_DSR = 1;
  localparam int L_RI  = 2;
  localparam int L_DCD = 3;

  localparam int C_DTR  = 0;
  localparam int C_RTS  = 1;
  localparam int C_OUT1 = 2;
  localparam int C_OUT2 = 3;
  localparam int C_LOOP = 4;

  localparam logic [LINES-1:0]  LINE_RST = 4'b1011;
  localparam logic [CTRL_W-1:0] CTRL_RST = 5'b01000;

  typedef enum logic {SEL_CTRL = 1'b0, SEL_STAT = 1'b1} reg_sel_e;
endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
  parameter int              W      = 4,
  parameter int              STAGES = 2,
  parameter logic [W-1:0]    RST    = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= RST;
    else         stg_q[0] <= d_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[g] <= RST;
      else         stg_q[g] <= stg_q[g-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/mdm_status.sv
module mdm_status
  import mdm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LINES-1:0]  line_i,
  input  logic              clr_i,
  output logic [BYTE_W-1:0] stat_o,
  output logic              any_o
);
  logic [LINES-1:0] lvl_q, dlt_q, dlt_new;

  always_comb begin
    dlt_new        = lvl_q ^ line_i;
    // ring flags the trailing edge only
    dlt_new[L_RI]  = lvl_q[L_RI] & ~line_i[L_RI];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= LINE_RST;
      dlt_q <= '0;
    end else begin
      lvl_q <= line_i;
      dlt_q <= (clr_i ? '0 : dlt_q) | dlt_new;
    end
  end

  assign stat_o = {lvl_q, dlt_q};
  assign any_o  = |dlt_q;

  p_delta_on_change_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_q[L_CTS] != $past(lvl_q[L_CTS])) |-> dlt_q[L_CTS]);

  p_delta_sticky_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dlt_q != '0 && !clr_i) |=> ((dlt_q & $past(dlt_q)) == $past(dlt_q)));

  p_ri_rise_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(lvl_q[L_RI]) && !$past(clr_i)) |-> (dlt_q[L_RI] == $past(dlt_q[L_RI])));

  p_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && line_i == lvl_q) |=> (dlt_q == '0));
endmodule

// File: rtl/mdm_ctrl.sv
module mdm_ctrl
  import mdm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [LINES-1:0]  pins_o,
  output logic              loop_o
);
  logic [CTRL_W-1:0] ctrl_q;
  logic              unused_hi;

  assign unused_hi = ^wdata_i[BYTE_W-1:CTRL_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ctrl_q <= CTRL_RST;
    else if (we_i) ctrl_q <= wdata_i[CTRL_W-1:0];
  end

  assign loop_o = ctrl_q[C_LOOP];
  assign ctrl_o = ctrl_q;
  // pins order {out2, out1, rts, dtr}, held inactive in loopback
  assign pins_o = loop_o ? '0 : ctrl_q[LINES-1:0];
endmodule

// File: rtl/mdm_regs.sv
module mdm_regs
  import mdm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_sel_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  input  logic              cts_i,
  input  logic              dsr_i,
  input  logic              dcd_i,
  input  logic              ri_i,
  output logic              dtr_o,
  output logic              rts_o,
  output logic              out1_o,
  output logic              out2_o,
  output logic              msc_irq_o
);
  logic [LINES-1:0]  line_raw, line_syn, pins;
  logic [CTRL_W-1:0] ctrl;
  logic [BYTE_W-1:0] stat, loop_img;
  logic              loop, stat_clr, any_dlt;
  reg_sel_e          sel;

  assign sel      = reg_sel_e'(reg_sel_i);
  assign line_raw = {dcd_i, ri_i, dsr_i, cts_i};

  mdm_sync #(.W(LINES), .STAGES(SYNC_STAGES), .RST(LINE_RST)) u_sync (
    .clk_i, .rst_ni, .d_i(line_raw), .q_o(line_syn)
  );

  assign stat_clr = rd_en_i && (sel == SEL_STAT) && !loop;

  mdm_status u_stat (
    .clk_i, .rst_ni, .line_i(line_syn), .clr_i(stat_clr),
    .stat_o(stat), .any_o(any_dlt)
  );

  mdm_ctrl u_ctrl (
    .clk_i, .rst_ni, .we_i(wr_en_i && (sel == SEL_CTRL)), .wdata_i,
    .ctrl_o(ctrl), .pins_o(pins), .loop_o(loop)
  );

  assign loop_img = {ctrl[C_OUT2], ctrl[C_OUT1], ctrl[C_DTR], ctrl[C_RTS], 4'b0000};

  always_comb begin
    if (sel == SEL_CTRL) rdata_o = {{(BYTE_W-CTRL_W){1'b0}}, ctrl};
    else if (loop)       rdata_o = loop_img;
    else                 rdata_o = stat;
  end

  assign dtr_o     = pins[C_DTR];
  assign rts_o     = pins[C_RTS];
  assign out1_o    = pins[C_OUT1];
  assign out2_o    = pins[C_OUT2];
  assign msc_irq_o = any_dlt;

  p_loop_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !reg_sel_i && wdata_i[C_LOOP]) |=> ({dtr_o, rts_o, out1_o, out2_o} == 4'b0000));

  p_irq_cleared_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && reg_sel_i && !loop && line_syn == stat[7:4]) |=> !msc_irq_o);
endmodule

// File: tb/tb_mdm_regs.sv
`timescale 1ns/1ps
module tb_mdm_regs;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       sel = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [7:0] wd = 8'h00, rdata;
  logic [3:0] ln = 4'b1011;   // {dcd, ri, dsr, cts}
  logic       dtr, rts, out1, out2, irq;

  int vectors = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  mdm_regs dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_sel_i(sel), .wr_en_i(wr), .rd_en_i(rd),
    .wdata_i(wd), .rdata_o(rdata), .cts_i(ln[0]), .dsr_i(ln[1]), .dcd_i(ln[3]),
    .ri_i(ln[2]), .dtr_o(dtr), .rts_o(rts), .out1_o(out1), .out2_o(out2),
    .msc_irq_o(irq)
  );

  // bench model
  logic [3:0] m_lvl = 4'b1011, m_dlt = 4'h0, m_s1 = 4'b1011, m_s2 = 4'b1011;
  logic [4:0] m_mcr = 5'h08;

  function automatic logic [7:0] exp_rd(input logic s);
    if (!s) return {3'b000, m_mcr};
    if (m_mcr[4]) return {m_mcr[3], m_mcr[2], m_mcr[0], m_mcr[1], 4'h0};
    return {m_lvl, m_dlt};
  endfunction

  function automatic logic [3:0] exp_pins();
    return m_mcr[4] ? 4'h0 : m_mcr[3:0];
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic cycle(input logic [3:0] l, input logic s, input logic w,
                       input logic r, input logic [7:0] d);
    logic [3:0] nd;
    @(negedge clk);
    ln = l; sel = s; wr = w; rd = r; wd = d;
    #1;
    chk(!s ? "R5 ctrl read" : (m_mcr[4] ? "R7 loop read" : "R2 status read"),
        rdata, exp_rd(s));
    chk(m_mcr[4] ? "R7 pins" : "R6 pins", {4'h0, out2, out1, rts, dtr}, {4'h0, exp_pins()});
    chk("R8 irq", {7'h0, irq}, {7'h0, |m_dlt});
    @(posedge clk);
    nd    = m_lvl ^ m_s2;
    nd[2] = m_lvl[2] & ~m_s2[2];
    m_dlt = ((r && s && !m_mcr[4]) ? 4'h0 : m_dlt) | nd;
    m_lvl = m_s2;
    m_s2  = m_s1;
    m_s1  = l;
    if (w && !s) m_mcr = d[4:0];
  endtask

  task automatic expect_stat(input string tag, input logic [7:0] exp);
    #1; sel = 1'b1; rd = 1'b0; wr = 1'b0; #1;
    chk(tag, rdata, exp);
  endtask

  initial begin
    int unsigned seed = 32'h1dd5_7a3c;
    logic [3:0] lr;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    sel = 1'b1; #1; chk("R1 status reset", rdata, 8'hB0);
    sel = 1'b0; #1; chk("R1 ctrl reset", rdata, 8'h08);
    chk("R1 pins reset", {4'h0, out2, out1, rts, dtr}, 8'h08);
    chk("R1 irq reset", {7'h0, irq}, 8'h00);

    // R9 latency of a cts drop
    cycle(4'b1010, 1, 0, 0, 0); expect_stat("R9 after edge 1", 8'hB0);
    cycle(4'b1010, 1, 0, 0, 0); expect_stat("R9 after edge 2", 8'hB0);
    cycle(4'b1010, 1, 0, 0, 0); expect_stat("R9 after edge 3", 8'hA1);
    // R4 clear
    cycle(4'b1010, 1, 0, 1, 0); expect_stat("R4 clear", 8'hA0);
    // R3 ring rise then fall
    repeat (3) cycle(4'b1110, 1, 0, 0, 0);
    expect_stat("R3 rise sets nothing", 8'hE0);
    repeat (3) cycle(4'b1010, 1, 0, 0, 0);
    expect_stat("R3 trailing edge", 8'hA4);
    cycle(4'b1010, 1, 0, 1, 0); expect_stat("R4 clear ring", 8'hA0);
    // R4 collision: dsr drop lands on clearing edge
    cycle(4'b1000, 1, 0, 0, 0);
    cycle(4'b1000, 1, 0, 0, 0);
    cycle(4'b1000, 1, 0, 1, 0); expect_stat("R4 collision kept", 8'h82);
    cycle(4'b1000, 1, 0, 1, 0); expect_stat("R4 clear again", 8'h80);
    // R5 / R6
    cycle(4'b1000, 0, 1, 0, 8'hE7);
    #1 sel = 1'b0; #1 chk("R5 ctrl masked", rdata, 8'h07);
    chk("R6 pins", {4'h0, out2, out1, rts, dtr}, 8'h07);
    cycle(4'b1000, 1, 1, 0, 8'h55); expect_stat("R5 status write ignored", 8'h80);
    #1 sel = 1'b0; #1 chk("R5 ctrl after status write", rdata, 8'h07);
    // R7 loopback
    cycle(4'b1000, 0, 1, 0, 8'h1D);
    #1 chk("R7 pins quiet", {4'h0, out2, out1, rts, dtr}, 8'h00);
    expect_stat("R7 image", 8'hE0);
    repeat (3) cycle(4'b1001, 1, 0, 1, 0);
    expect_stat("R7 image holds", 8'hE0);
    #1 chk("R8 irq in loop", {7'h0, irq}, 8'h01);
    cycle(4'b1001, 0, 1, 0, 8'h00); expect_stat("R7 deltas kept", 8'h91);

    // seeded random traffic
    lr = 4'b1001;
    for (int i = 0; i < 4000; i++) begin
      for (int b = 0; b < 4; b++) if ($urandom_range(7) == 0) lr[b] = ~lr[b];
      cycle(lr, 1'($urandom_range(1)), $urandom_range(7) == 0,
            $urandom_range(2) == 0, 8'($urandom));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule